// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Tagged Queue

This block turns an asynchronous serial line into characters. The line rests high. A low level seen on an oversampling tick starts a candidate start bit. The candidate is confirmed at the middle of the bit. The data bits, an optional parity bit and the stop bit are then each sampled once, at the middle of their bit periods. The oversampling tick comes from outside. The tick rate is either 16 or 8 ticks per bit, chosen by a mode input. Character length and parity are set by line-control inputs. These inputs are held steady while a character is in flight.

Each finished character goes into a small queue together with four status bits. The status word, from MSB to LSB, is `{framing, parity, break, overrun}`. The reader sees the oldest entry at the queue head and removes it with a one-cycle read strobe.

The control is a six-state machine:
- IDLE goes to START when the line is low on a tick.
- START goes to DATA if the line is still low at mid-bit, and back to IDLE if the line is high there.
- DATA goes to PARITY after the last data bit when parity is enabled, and to STOP otherwise.
- PARITY goes to STOP after one bit.
- STOP goes to IDLE if the stop bit is high, and to HOLD if it is low.
- HOLD goes to IDLE on a tick where the line is high.

Top module: `osr_uart_rx`

## Requirements
- R1: While reset is asserted and right after it is released, the queue is empty: `rd_empty_o`=1, and `rd_data_o`/`rd_stat_o` carry no entry.
- R2: In IDLE, a tick with `rx_i`=0 counts as tick 1 of a candidate start bit. The start bit is confirmed only if `rx_i` is still 0 on tick 8 (`os_mode8_i`=0) or tick 4 (`os_mode8_i`=1). If it is not, the machine returns to IDLE and nothing is stored.
- R3: After a confirmed start bit, each following bit is sampled once every 16 ticks (16x mode) or every 8 ticks (8x mode). Data arrives LSB first. The data length is 5+`len_sel_i` bits, and the unused upper bits of `rd_data_o` read 0.
- R4: When `par_en_i`=1, one parity bit follows the data bits. With `par_odd_i`=0 it is expected to equal the XOR of the data bits, and with `par_odd_i`=1 it is expected to equal the inverse of that XOR. A mismatch sets status bit 2. When `par_en_i`=0 no parity bit is sent and bit 2 stays 0.
- R5: A stop bit sampled low sets status bit 3 (framing). A stop bit sampled high leaves bit 3 clear.
- R6: Status bit 1 (break) is set when the data bits, the parity bit (if enabled) and the stop bit were all sampled 0.
- R7: After a stop bit sampled low, no new character starts until `rx_i` has been seen high on a tick.
- R8: Entries are read in arrival order. `rd_en_i`=1 removes the head entry when the queue is not empty, and has no effect when it is empty.
- R9: A character that completes while the queue holds DEPTH entries is dropped. Status bit 0 (overrun) is set on the newest stored entry, and the older entries keep bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle oversampling tick |
| os_mode8_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| len_sel_i | input | 2 | Data length select, bits = 5 + value |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| rd_en_i | input | 1 | Remove head entry |
| rd_data_o | output | 8 | Head entry character |
| rd_stat_o | output | 4 | Head entry status {framing, parity, break, overrun} |
| rd_empty_o | output | 1 | Queue holds no entry |

## Verification
Random frames mix both tick rates, all four lengths and every parity setting. Some of these frames carry a deliberately wrong parity bit or a low stop bit, which separates a wrong sampling position or bit order (a bad data value) from wrong error decoding (a bad status value). Two directed cases cover the start bit. A short low pulse in each mode checks that the start bit is rejected before mid-bit. A long, all-zero low period separates a break from a plain framing error and checks that the line is not re-armed while it stays low. Sending more frames than the queue holds, with no read in between, checks that the right character is dropped and that the overrun flag lands on the right entry. A read strobe on an empty queue is checked by showing that the next character still arrives intact.

// File: rtl/osr_uart_rx_pkg.sv
package osr_uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    // status captured by the receiver; overrun is added in the queue
    typedef struct packed {
        logic ferr;
        logic perr;
        logic brk;
    } rx_flags_t;

endpackage

// File: rtl/osr_rx_fsm.sv
module osr_rx_fsm
    import osr_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              mode8_i,
    input  logic [LEN_W-1:0]  len_sel_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    output logic              busy_o,
    output logic              push_o,
    output logic [DATA_W-1:0] data_o,
    output rx_flags_t         flags_o
);

    localparam int CNT_W    = $clog2(OVS_HI);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic [CNT_W-1:0]  mid_lim, bit_lim;
    logic [BIT_W-1:0]  last_idx;
    logic              mid_hit, bit_hit;

    always_comb begin
        mid_lim  = mode8_i ? CNT_W'(OVS_LO / 2 - 1) : CNT_W'(OVS_HI / 2 - 1);
        bit_lim  = mode8_i ? CNT_W'(OVS_LO - 1) : CNT_W'(OVS_HI - 1);
        last_idx = BIT_W'(MIN_BITS - 1) + BIT_W'(len_sel_i);
        mid_hit  = tick_i && (cnt == mid_lim);
        bit_hit  = tick_i && (cnt == bit_lim);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt    = state;
        busy_o = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   if (tick_i && !rx_i) nxt = ST_START;
            ST_START:  if (mid_hit) nxt = rx_i ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_hit && bit_idx == last_idx)
                           nxt = par_en_i ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_hit) nxt = ST_STOP;
            ST_STOP:   if (bit_hit) nxt = rx_i ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (tick_i && rx_i) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath: tick counter, shift register, result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            push_o  <= 1'b0;
            data_o  <= '0;
            flags_o <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    ST_IDLE: begin
                        cnt     <= CNT_W'(1);
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                    end
                    ST_START: cnt <= mid_hit ? '0 : cnt + 1'b1;
                    ST_DATA: begin
                        cnt <= bit_hit ? '0 : cnt + 1'b1;
                        if (bit_hit) begin
                            shreg[bit_idx] <= rx_i;
                            bit_idx        <= bit_idx + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        cnt <= bit_hit ? '0 : cnt + 1'b1;
                        if (bit_hit) par_bit <= rx_i;
                    end
                    ST_STOP: begin
                        cnt <= bit_hit ? '0 : cnt + 1'b1;
                        if (bit_hit) begin
                            push_o       <= 1'b1;
                            data_o       <= shreg;
                            flags_o.ferr <= !rx_i;
                            flags_o.perr <= par_en_i && (par_bit != ((^shreg) ^ par_odd_i));
                            flags_o.brk  <= !rx_i && (shreg == '0) && !(par_en_i && par_bit);
                        end
                    end
                    ST_HOLD: cnt <= '0;
                    default: cnt <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/osr_rx_queue.sv
module osr_rx_queue
    import osr_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  rx_flags_t         flags_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_data_o,
    output logic [3:0]        head_stat_o,
    output logic              empty_o,
    output logic              full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] data_mem [DEPTH];
    rx_flags_t         flag_mem [DEPTH];
    logic [DEPTH-1:0]  ovr_mem;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, newest;
    logic [CNT_W-1:0]  count;
    logic              do_wr, do_rd;

    always_comb begin
        empty_o = (count == '0);
        full_o  = (count == CNT_W'(DEPTH));
        do_wr   = push_i && !full_o;
        do_rd   = pop_i && !empty_o;
        newest  = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
        head_data_o = data_mem[rd_ptr];
        head_stat_o = {flag_mem[rd_ptr], ovr_mem[rd_ptr]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            ovr_mem <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                data_mem[i] <= '0;
                flag_mem[i] <= '0;
            end
        end else begin
            if (do_wr) begin
                data_mem[wr_ptr] <= data_i;
                flag_mem[wr_ptr] <= flags_i;
                ovr_mem[wr_ptr]  <= 1'b0;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end else if (push_i) begin
                ovr_mem[newest] <= 1'b1;
            end
            if (do_rd)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              os_mode8_i,
    input  logic [LEN_W-1:0]  len_sel_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [3:0]        rd_stat_o,
    output logic              rd_empty_o
);

    logic              busy_w, push_w, full_w;
    logic [DATA_W-1:0] pdata_w;
    rx_flags_t         pflags_w;

    osr_rx_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_i),
        .tick_i    (os_tick_i),
        .mode8_i   (os_mode8_i),
        .len_sel_i (len_sel_i),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .busy_o    (busy_w),
        .push_o    (push_w),
        .data_o    (pdata_w),
        .flags_o   (pflags_w)
    );

    osr_rx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_w),
        .data_i      (pdata_w),
        .flags_i     (pflags_w),
        .pop_i       (rd_en_i),
        .head_data_o (rd_data_o),
        .head_stat_o (rd_stat_o),
        .empty_o     (rd_empty_o),
        .full_o      (full_w)
    );

endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_i,
    input logic       os_tick_i,
    input logic       rd_en_i,
    input logic       rd_empty_o,
    input logic       busy_w,
    input logic       push_w,
    input logic       full_w,
    input logic [2:0] pflags_w
);

    // R1
    rst_empty_chk: assert property (@(posedge clk) !rst_n |=> rd_empty_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w && os_tick_i && rx_i |=> !busy_w);

    // R3
    push_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_w |-> $past(os_tick_i));

    // R5
    frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_w |-> (pflags_w[2] == !$past(rx_i)));

    // R6
    brk_implies_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_w && pflags_w[0] |-> pflags_w[2]);

    // R7
    hold_after_low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_w && pflags_w[2] |-> busy_w);

    // R8
    empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty_o && !push_w |=> rd_empty_o);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_w && push_w && !rd_en_i |=> full_w);

endmodule

bind osr_uart_rx osr_uart_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx_i),
    .os_tick_i  (os_tick_i),
    .rd_en_i    (rd_en_i),
    .rd_empty_o (rd_empty_o),
    .busy_w     (busy_w),
    .push_w     (push_w),
    .full_w     (full_w),
    .pflags_w   (pflags_w)
);

// File: tb/sim_osr_uart_rx.sv
`timescale 1ns/1ps
module sim_osr_uart_rx;

    localparam int DEPTH   = 4;
    localparam int TICKDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       mode8 = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] rd_stat;
    logic       rd_empty;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    osr_uart_rx #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .os_mode8_i(mode8), .len_sel_i(len_sel), .par_en_i(par_en),
        .par_odd_i(par_odd), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rd_stat_o(rd_stat), .rd_empty_o(rd_empty)
    );

    initial begin
        forever begin
            repeat (TICKDIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic int bit_clks();
        return (mode8 ? 8 : 16) * TICKDIV;
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] ls);
        return 8'hFF >> (3 - ls);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic odd, input logic force_bad);
        return (^d) ^ odd ^ force_bad;
    endfunction

    function automatic logic [11:0] expect_entry(input logic [7:0] d, input logic [1:0] ls,
            input logic pe, input logic po, input logic pbad, input logic stopv, input logic ovr);
        logic [7:0] m;
        logic       pb, ferr, perr, brk;
        m    = d & len_mask(ls);
        pb   = par_of(m, po, pbad);
        ferr = !stopv;
        perr = pe && pbad;
        brk  = !stopv && (m == 8'd0) && !(pe && pb);
        return {ferr, perr, brk, ovr, m};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rx = v;
        repeat (bit_clks() - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pbad, input logic stopv);
        logic [7:0] m;
        m = d & len_mask(len_sel);
        drive_bit(1'b0);
        for (int i = 0; i < 5 + int'(len_sel); i++) drive_bit(m[i]);
        if (par_en) drive_bit(par_of(m, par_odd, pbad));
        drive_bit(stopv);
        @(negedge clk);
        rx = 1'b1;
        repeat (2 * bit_clks()) @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [11:0] exp);
        @(negedge clk);
        check(req, {31'd0, rd_empty}, 32'd0);
        check(req, {20'd0, rd_stat, rd_data}, {20'd0, exp});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic empty_check(input string req);
        @(negedge clk);
        check(req, {31'd0, rd_empty}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: queue empty under reset and after release
        check("R1 empty in reset", {31'd0, rd_empty}, 32'd1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 empty after reset", {31'd0, rd_empty}, 32'd1);
        check("R1 status clear", {28'd0, rd_stat}, 32'd0);

        // R2: short low pulse rejected, 16x mode (6 ticks low)
        mode8 = 1'b0;
        @(negedge clk); rx = 1'b0;
        repeat (6 * TICKDIV) @(negedge clk);
        rx = 1'b1;
        repeat (40 * TICKDIV) @(negedge clk);
        empty_check("R2 glitch rejected 16x");

        // R2: short low pulse rejected, 8x mode (2 ticks low)
        mode8 = 1'b1;
        @(negedge clk); rx = 1'b0;
        repeat (2 * TICKDIV) @(negedge clk);
        rx = 1'b1;
        repeat (20 * TICKDIV) @(negedge clk);
        empty_check("R2 glitch rejected 8x");

        // R8: read strobe on empty queue has no effect
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        empty_check("R8 empty read ignored");
        len_sel = 2'd3; par_en = 1'b0;
        send_frame(8'hA5, 1'b0, 1'b1);
        read_check("R8 R3 frame after empty read", expect_entry(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        empty_check("R8 empty after pop");

        // R6 R7: held-low break, a single entry only
        mode8 = 1'b0; len_sel = 2'd3; par_en = 1'b0;
        drive_bit(1'b0);
        repeat (8) drive_bit(1'b0);
        drive_bit(1'b0);
        repeat (3) drive_bit(1'b0);
        @(negedge clk); rx = 1'b1;
        repeat (2 * bit_clks()) @(negedge clk);
        read_check("R6 break entry", expect_entry(8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        empty_check("R7 no restart while low");

        // R5: low stop with nonzero data is framing only
        mode8 = 1'b1; len_sel = 2'd1; par_en = 1'b1; par_odd = 1'b1;
        send_frame(8'h21, 1'b0, 1'b0);
        read_check("R5 framing error", expect_entry(8'h21, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));

        // R9: overrun
        mode8 = 1'b1; len_sel = 2'd3; par_en = 1'b0;
        for (int k = 0; k <= DEPTH; k++) send_frame(8'(8'h30 + k), 1'b0, 1'b1);
        for (int k = 0; k < DEPTH; k++)
            read_check("R9 overrun queue", expect_entry(8'(8'h30 + k), 2'd3, 1'b0, 1'b0, 1'b0, 1'b1,
                                                       (k == DEPTH - 1)));
        empty_check("R9 dropped frame absent");

        // R3 R4 R5 R6: random frames
        for (int n = 0; n < 36; n++) begin
            logic [7:0] d;
            logic       pbad, stopv;
            mode8   = 1'($urandom % 2);
            len_sel = 2'($urandom % 4);
            par_en  = 1'($urandom % 2);
            par_odd = 1'($urandom % 2);
            d       = ($urandom % 5 == 0) ? 8'd0 : 8'($urandom);
            pbad    = ($urandom % 5 == 0);
            stopv   = ($urandom % 6 != 0);
            send_frame(d, pbad, stopv);
            read_check("R3 R4 R5 R6 random frame",
                       expect_entry(d, len_sel, par_en, par_odd, pbad, stopv, 1'b0));
        end
        empty_check("R8 drained");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule